// File: doc/BRIEF.md
# Accelerator Command and Data Port

This block joins a host-side bus agent to a single accelerator engine over one clock. Traffic in each direction travels as two ordered streams: a queue of command headers and a queue of payload beats. A header names the kind of transfer and its size. The payload beats that belong to it sit in the data queue in the same order as the headers, so the n-th header owns the n-th group of beats.

On the way in, from host to engine, a dispatcher reads the header at the head of its queue and pairs it with its payload. Register accesses, either a write or an update, leave on a register port that carries one data word each. Bulk transfers leave on a separate bulk port as a counted burst that ends with a marker on its final beat. A bulk read request leaves as a single beat that carries no data.

A bulk header with an illegal length is retired without producing any output. The block raises a one-cycle error flag and throws away that header's payload. Every outgoing port waits for its receiver, and a burst may stall anywhere without changing what is delivered. On the way out, from engine to host, headers and data pass through their own queues unchanged and keep their order.

Top module: `acp_port`

## Requirements
- R1: A header is 28 bits wide. Bits [27:26] hold the transfer kind: 00 register write, 01 register update, 10 bulk write, 11 bulk read request. For register kinds, bits [15:0] give the register address. For bulk kinds, bits [25:0] give the length in bytes.
- R2: A register header is paired with exactly one data beat. It appears on the register port with `csr_kind` (0 for write, 1 for update), the address and the data. The header and the beat are both retired in the cycle of the register handshake.
- R3: A bulk write with a legal length L sends exactly L/64 beats on the bulk port, in data-queue order. `bk_beats` equals L/64 on every beat, `bk_rd` is 0, and `bk_last` is 1 only on the final beat.
- R4: A legal bulk read request sends exactly one bulk-port transfer with `bk_rd`=1, `bk_last`=1, `bk_beats`=L/64 and all-zero data. It takes no beat from the data queue.
- R5: A bulk length is legal only if it is a multiple of 64, at least 64 and at most 4194304. An illegal bulk header produces nothing on either output port. A bulk write with an illegal length discards floor(L/64) data beats; a bulk read with an illegal length discards none. `err_len` is high for exactly the one cycle in which the illegal header is retired.
- R6: Payloads stay paired with their headers in order. A header leaves its queue only when its last beat is consumed, and no beat is lost or duplicated.
- R7: On the register port and the bulk port, while valid is high and ready is low, valid stays high and the presented values stay stable in the next cycle.
- R8: Each of the four queues holds DEPTH entries, and its input ready is low while it is full. `q_full` and `q_empty` are indexed as follows: bit 0 host-to-engine commands, bit 1 host-to-engine data, bit 2 engine-to-host commands, bit 3 engine-to-host data.
- R9: Engine-to-host headers and data emerge unchanged and in order on `rcmd_*` and `rdat_*`. Each stream is held stable while it is stalled.
- R10: After reset all queues are empty, every output valid is low and `err_len` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hcmd_valid | input | 1 | Host header offered |
| hcmd_ready | output | 1 | Host header queue has room |
| hcmd_hdr | input | 28 | Host header |
| hdat_valid | input | 1 | Host data beat offered |
| hdat_ready | output | 1 | Host data queue has room |
| hdat_data | input | DATA_W | Host data beat |
| csr_valid | output | 1 | Register access presented |
| csr_ready | input | 1 | Engine accepts register access |
| csr_kind | output | 1 | 0 write, 1 update |
| csr_addr | output | 16 | Register address |
| csr_data | output | DATA_W | Register data word |
| bk_valid | output | 1 | Bulk beat presented |
| bk_ready | input | 1 | Engine accepts bulk beat |
| bk_rd | output | 1 | Beat is a bulk read request |
| bk_last | output | 1 | Final beat of the transfer |
| bk_beats | output | 20 | Transfer length in 64-byte units |
| bk_data | output | DATA_W | Bulk beat data |
| err_len | output | 1 | Illegal bulk length retired this cycle |
| ecmd_valid | input | 1 | Engine header offered |
| ecmd_ready | output | 1 | Engine header queue has room |
| ecmd_hdr | input | 28 | Engine header |
| edat_valid | input | 1 | Engine data beat offered |
| edat_ready | output | 1 | Engine data queue has room |
| edat_data | input | DATA_W | Engine data beat |
| rcmd_valid | output | 1 | Return header available to host |
| rcmd_ready | input | 1 | Host takes return header |
| rcmd_hdr | output | 28 | Return header |
| rdat_valid | output | 1 | Return data available to host |
| rdat_ready | input | 1 | Host takes return data |
| rdat_data | output | DATA_W | Return data beat |
| q_full | output | 4 | Queue full flags |
| q_empty | output | 4 | Queue empty flags |

## Verification
The hold properties assume that a receiver lowering ready is the only thing that stalls a presented beat. They therefore rely on the dispatcher never popping a queue unless that queue shows a valid head, and the bench never forces a pop from outside. The length-error properties assume that every header's payload is eventually supplied in full. The stimulus enforces this by generating each header together with exactly the number of data beats that R2, R3 and R5 attach to it. Senders only present a beat when they own one, while valid and ready on both sides are randomised per cycle at several stall rates.

// File: rtl/acp_pkg.sv
package acp_pkg;
   localparam int HDR_W      = 28;
   localparam int LEN_W      = 26;
   localparam int ADDR_W     = 16;
   localparam int UNIT_SHIFT = 6;
   localparam int BEAT_W     = LEN_W - UNIT_SHIFT;
   localparam int MAX_BYTES  = 4194304;

   typedef enum logic [1:0] {
      KIND_CSR_WR  = 2'b00,
      KIND_CSR_UPD = 2'b01,
      KIND_BULK_WR = 2'b10,
      KIND_BULK_RD = 2'b11
   } acp_kind_e;
endpackage

// File: rtl/acp_fifo.sv
module acp_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_valid,
   output logic         wr_ready,
   input  logic [W-1:0] wr_data,
   input  logic         rd_pop,
   output logic [W-1:0] rd_data,
   output logic         full,
   output logic         empty
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_depth_bad
         $error("acp_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wptr, rptr;
   logic         push, pop;

   assign full     = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
   assign empty    = (wptr == rptr);
   assign wr_ready = !full;
   assign push     = wr_valid && !full;
   assign pop      = rd_pop && !empty;
   assign rd_data  = mem[rptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (push) mem[wptr[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (push) wptr <= wptr + 1'b1;
         if (pop)  rptr <= rptr + 1'b1;
      end
   end
endmodule

// File: rtl/acp_hdr_dec.sv
module acp_hdr_dec
   import acp_pkg::*;
(
   input  logic [HDR_W-1:0]  hdr,
   output acp_kind_e         kind,
   output logic [ADDR_W-1:0] addr,
   output logic [BEAT_W-1:0] beats,
   output logic              len_ok
);
   logic [LEN_W-1:0] bytes;

   assign kind   = acp_kind_e'(hdr[HDR_W-1 -: 2]);
   assign bytes  = hdr[LEN_W-1:0];
   assign addr   = bytes[ADDR_W-1:0];
   assign beats  = bytes[LEN_W-1:UNIT_SHIFT];
   assign len_ok = (bytes[UNIT_SHIFT-1:0] == '0)
                && (beats != '0)
                && (bytes <= LEN_W'(MAX_BYTES));
endmodule

// File: rtl/acp_h2e_disp.sv
module acp_h2e_disp
   import acp_pkg::*;
#(
   parameter int DATA_W = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_empty,
   input  logic [HDR_W-1:0]  cmd_hdr,
   input  logic              dat_empty,
   input  logic [DATA_W-1:0] dat_word,
   output logic              cmd_pop,
   output logic              dat_pop,
   output logic              csr_valid,
   input  logic              csr_ready,
   output logic              csr_kind,
   output logic [ADDR_W-1:0] csr_addr,
   output logic [DATA_W-1:0] csr_data,
   output logic              bk_valid,
   input  logic              bk_ready,
   output logic              bk_rd,
   output logic              bk_last,
   output logic [BEAT_W-1:0] bk_beats,
   output logic [DATA_W-1:0] bk_data,
   output logic              err_len
);
   acp_kind_e         kind;
   logic [BEAT_W-1:0] beats, cnt;
   logic              len_ok, have_hdr, have_dat, last_beat;

   acp_hdr_dec u_dec (
      .hdr(cmd_hdr), .kind(kind), .addr(csr_addr), .beats(beats), .len_ok(len_ok)
   );

   assign have_hdr  = !cmd_empty;
   assign have_dat  = !dat_empty;
   assign last_beat = (cnt == beats - 1'b1);
   assign csr_kind  = kind[0];
   assign csr_data  = dat_word;
   assign bk_rd     = have_hdr && (kind == KIND_BULK_RD);
   assign bk_last   = bk_rd || last_beat;
   assign bk_beats  = beats;
   assign bk_data   = bk_rd ? '0 : dat_word;

   always_comb begin
      cmd_pop   = 1'b0;
      dat_pop   = 1'b0;
      csr_valid = 1'b0;
      bk_valid  = 1'b0;
      err_len   = 1'b0;
      if (have_hdr) begin
         unique case (kind)
            KIND_CSR_WR, KIND_CSR_UPD: begin
               csr_valid = have_dat;
               cmd_pop   = have_dat && csr_ready;
               dat_pop   = have_dat && csr_ready;
            end
            KIND_BULK_WR: begin
               if (len_ok) begin
                  bk_valid = have_dat;
                  dat_pop  = have_dat && bk_ready;
                  cmd_pop  = have_dat && bk_ready && last_beat;
               end else if (beats == '0) begin
                  cmd_pop = 1'b1;
                  err_len = 1'b1;
               end else begin
                  dat_pop = have_dat;
                  cmd_pop = have_dat && last_beat;
                  err_len = have_dat && last_beat;
               end
            end
            default: begin
               if (len_ok) begin
                  bk_valid = 1'b1;
                  cmd_pop  = bk_ready;
               end else begin
                  cmd_pop = 1'b1;
                  err_len = 1'b1;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (cmd_pop) cnt <= '0;
      else if (dat_pop) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/acp_port.sv
module acp_port
   import acp_pkg::*;
#(
   parameter int DATA_W = 512,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hcmd_valid,
   output logic              hcmd_ready,
   input  logic [HDR_W-1:0]  hcmd_hdr,
   input  logic              hdat_valid,
   output logic              hdat_ready,
   input  logic [DATA_W-1:0] hdat_data,
   output logic              csr_valid,
   input  logic              csr_ready,
   output logic              csr_kind,
   output logic [ADDR_W-1:0] csr_addr,
   output logic [DATA_W-1:0] csr_data,
   output logic              bk_valid,
   input  logic              bk_ready,
   output logic              bk_rd,
   output logic              bk_last,
   output logic [BEAT_W-1:0] bk_beats,
   output logic [DATA_W-1:0] bk_data,
   output logic              err_len,
   input  logic              ecmd_valid,
   output logic              ecmd_ready,
   input  logic [HDR_W-1:0]  ecmd_hdr,
   input  logic              edat_valid,
   output logic              edat_ready,
   input  logic [DATA_W-1:0] edat_data,
   output logic              rcmd_valid,
   input  logic              rcmd_ready,
   output logic [HDR_W-1:0]  rcmd_hdr,
   output logic              rdat_valid,
   input  logic              rdat_ready,
   output logic [DATA_W-1:0] rdat_data,
   output logic [3:0]        q_full,
   output logic [3:0]        q_empty
);
   localparam int NDIR = 2;

   logic              c_wv [NDIR], c_wr [NDIR], c_pop [NDIR], c_full [NDIR], c_empty [NDIR];
   logic              d_wv [NDIR], d_wr [NDIR], d_pop [NDIR], d_full [NDIR], d_empty [NDIR];
   logic [HDR_W-1:0]  c_in [NDIR], c_out [NDIR];
   logic [DATA_W-1:0] d_in [NDIR], d_out [NDIR];

   assign c_wv[0] = hcmd_valid;  assign c_in[0] = hcmd_hdr;
   assign c_wv[1] = ecmd_valid;  assign c_in[1] = ecmd_hdr;
   assign d_wv[0] = hdat_valid;  assign d_in[0] = hdat_data;
   assign d_wv[1] = edat_valid;  assign d_in[1] = edat_data;

   generate
      for (genvar gd = 0; gd < NDIR; gd++) begin : g_dir
         acp_fifo #(.W(HDR_W), .DEPTH(DEPTH)) u_cmd_q (
            .clk(clk), .rst_n(rst_n), .wr_valid(c_wv[gd]), .wr_ready(c_wr[gd]),
            .wr_data(c_in[gd]), .rd_pop(c_pop[gd]), .rd_data(c_out[gd]),
            .full(c_full[gd]), .empty(c_empty[gd])
         );
         acp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_dat_q (
            .clk(clk), .rst_n(rst_n), .wr_valid(d_wv[gd]), .wr_ready(d_wr[gd]),
            .wr_data(d_in[gd]), .rd_pop(d_pop[gd]), .rd_data(d_out[gd]),
            .full(d_full[gd]), .empty(d_empty[gd])
         );
      end
   endgenerate

   assign hcmd_ready = c_wr[0];
   assign hdat_ready = d_wr[0];
   assign ecmd_ready = c_wr[1];
   assign edat_ready = d_wr[1];

   acp_h2e_disp #(.DATA_W(DATA_W)) u_disp (
      .clk(clk), .rst_n(rst_n),
      .cmd_empty(c_empty[0]), .cmd_hdr(c_out[0]),
      .dat_empty(d_empty[0]), .dat_word(d_out[0]),
      .cmd_pop(c_pop[0]), .dat_pop(d_pop[0]),
      .csr_valid(csr_valid), .csr_ready(csr_ready), .csr_kind(csr_kind),
      .csr_addr(csr_addr), .csr_data(csr_data),
      .bk_valid(bk_valid), .bk_ready(bk_ready), .bk_rd(bk_rd), .bk_last(bk_last),
      .bk_beats(bk_beats), .bk_data(bk_data), .err_len(err_len)
   );

   assign rcmd_valid = !c_empty[1];
   assign rcmd_hdr   = c_out[1];
   assign c_pop[1]   = rcmd_valid && rcmd_ready;
   assign rdat_valid = !d_empty[1];
   assign rdat_data  = d_out[1];
   assign d_pop[1]   = rdat_valid && rdat_ready;

   assign q_full  = {d_full[1], c_full[1], d_full[0], c_full[0]};
   assign q_empty = {d_empty[1], c_empty[1], d_empty[0], c_empty[0]};
endmodule

// File: rtl/acp_port_chk.sv
module acp_port_chk
   import acp_pkg::*;
#(
   parameter int DATA_W = 512
) (
   input logic              clk,
   input logic              rst_n,
   input logic              csr_valid,
   input logic              csr_ready,
   input logic              csr_kind,
   input logic [ADDR_W-1:0] csr_addr,
   input logic [DATA_W-1:0] csr_data,
   input logic              bk_valid,
   input logic              bk_ready,
   input logic              bk_rd,
   input logic              bk_last,
   input logic [BEAT_W-1:0] bk_beats,
   input logic [DATA_W-1:0] bk_data,
   input logic              err_len,
   input logic              rcmd_valid,
   input logic              rcmd_ready,
   input logic [HDR_W-1:0]  rcmd_hdr,
   input logic [3:0]        q_full,
   input logic [3:0]        q_empty
);
   AST_CSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      csr_valid && !csr_ready |=> csr_valid && $stable(csr_kind) && $stable(csr_addr) && $stable(csr_data)); // R7
   AST_BK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bk_valid && !bk_ready |=> bk_valid && $stable(bk_data) && $stable(bk_last) && $stable(bk_rd)); // R7
   AST_BK_LEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      bk_valid && bk_ready && !bk_last |=> $stable(bk_beats)); // R3
   AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      bk_valid && bk_rd |-> bk_last); // R4
   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      err_len |-> !bk_valid && !csr_valid); // R5
   AST_RET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rcmd_valid && !rcmd_ready |=> rcmd_valid && $stable(rcmd_hdr)); // R9
   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (q_full & q_empty) == 4'b0000); // R8
endmodule

bind acp_port acp_port_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .csr_valid(csr_valid), .csr_ready(csr_ready), .csr_kind(csr_kind),
   .csr_addr(csr_addr), .csr_data(csr_data),
   .bk_valid(bk_valid), .bk_ready(bk_ready), .bk_rd(bk_rd), .bk_last(bk_last),
   .bk_beats(bk_beats), .bk_data(bk_data), .err_len(err_len),
   .rcmd_valid(rcmd_valid), .rcmd_ready(rcmd_ready), .rcmd_hdr(rcmd_hdr),
   .q_full(q_full), .q_empty(q_empty)
);

// File: tb/acp_port_tb.sv
module acp_port_tb;
   import acp_pkg::*;
   localparam int DW = 32;
   localparam int DP = 4;

   typedef struct packed {
      logic              rd;
      logic              last;
      logic [BEAT_W-1:0] beats;
      logic [DW-1:0]     data;
   } bk_t;
   typedef struct packed {
      logic              kind;
      logic [ADDR_W-1:0] addr;
      logic [DW-1:0]     data;
   } csr_t;

   logic clk = 0, rst_n = 0;
   always #2 clk = ~clk;

   logic hcmd_valid = 0, hdat_valid = 0, ecmd_valid = 0, edat_valid = 0;
   logic csr_ready = 0, bk_ready = 0, rcmd_ready = 0, rdat_ready = 0;
   logic [HDR_W-1:0] hcmd_hdr = '0, ecmd_hdr = '0;
   logic [DW-1:0] hdat_data = '0, edat_data = '0;
   logic hcmd_ready, hdat_ready, ecmd_ready, edat_ready;
   logic csr_valid, csr_kind, bk_valid, bk_rd, bk_last, err_len, rcmd_valid, rdat_valid;
   logic [ADDR_W-1:0] csr_addr;
   logic [DW-1:0] csr_data, bk_data, rdat_data;
   logic [BEAT_W-1:0] bk_beats;
   logic [HDR_W-1:0] rcmd_hdr;
   logic [3:0] q_full, q_empty;

   acp_port #(.DATA_W(DW), .DEPTH(DP)) u_dut (.*);

   logic [HDR_W-1:0] hc_src[$], ec_src[$], rc_exp[$];
   logic [DW-1:0]    hd_src[$], ed_src[$], rd_exp[$];
   csr_t csr_exp[$];
   bk_t  bk_exp[$];
   int checks = 0, fails = 0, err_exp = 0, err_seen = 0;
   logic [DW-1:0] seq = 32'h1000;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
      end
   endtask

   // R1 header layout: kind in [27:26], address [15:0] or byte length [25:0]
   task automatic add_cmd(input logic [1:0] kind, input int unsigned field);
      int unsigned beats = field >> 6;
      bit ok = (field % 64 == 0) && (field >= 64) && (field <= 4194304);
      hc_src.push_back({kind, field[25:0]});
      if (kind[1] == 1'b0) begin
         seq++;
         hd_src.push_back(seq);
         csr_exp.push_back('{kind[0], field[15:0], seq});
      end else if (kind == 2'b10) begin
         for (int i = 0; i < int'(beats); i++) begin
            seq++;
            hd_src.push_back(seq);
            if (ok) bk_exp.push_back('{1'b0, i == int'(beats) - 1, beats[BEAT_W-1:0], seq});
         end
         if (!ok) err_exp++;
      end else begin
         if (ok) bk_exp.push_back('{1'b1, 1'b1, beats[BEAT_W-1:0], '0});
         else err_exp++;
      end
   endtask

   task automatic add_ret(input int n);
      for (int i = 0; i < n; i++) begin
         logic [HDR_W-1:0] h = HDR_W'($urandom);
         logic [DW-1:0] d = $urandom;
         ec_src.push_back(h); rc_exp.push_back(h);
         ed_src.push_back(d); rd_exp.push_back(d);
      end
   endtask

   function automatic bit go(input int stall);
      return ($urandom % 100) >= stall;
   endfunction

   task automatic run(input int stall, input bit hold_out, input int max_cyc);
      for (int cyc = 0; cyc < max_cyc; cyc++) begin
         @(negedge clk);
         hcmd_valid = hc_src.size() > 0 && go(stall);
         hcmd_hdr   = hc_src.size() > 0 ? hc_src[0] : '0;
         hdat_valid = hd_src.size() > 0 && go(stall);
         hdat_data  = hd_src.size() > 0 ? hd_src[0] : '0;
         ecmd_valid = ec_src.size() > 0 && go(stall);
         ecmd_hdr   = ec_src.size() > 0 ? ec_src[0] : '0;
         edat_valid = ed_src.size() > 0 && go(stall);
         edat_data  = ed_src.size() > 0 ? ed_src[0] : '0;
         csr_ready  = !hold_out && go(stall);
         bk_ready   = !hold_out && go(stall);
         rcmd_ready = !hold_out && go(stall);
         rdat_ready = !hold_out && go(stall);
         #1;
         if (hcmd_valid && hcmd_ready) void'(hc_src.pop_front());
         if (hdat_valid && hdat_ready) void'(hd_src.pop_front());
         if (ecmd_valid && ecmd_ready) void'(ec_src.pop_front());
         if (edat_valid && edat_ready) void'(ed_src.pop_front());
         if (err_len) err_seen++;
         if (csr_valid && csr_ready) begin
            csr_t e = csr_exp.size() > 0 ? csr_exp.pop_front() : '1;
            chk(csr_kind == e.kind && csr_addr == e.addr && csr_data == e.data, "R2",
                "register access", {csr_kind, csr_addr, csr_data}, {e.kind, e.addr, e.data});
         end
         if (bk_valid && bk_ready) begin
            bk_t e = bk_exp.size() > 0 ? bk_exp.pop_front() : '1;
            bk_t g = '{bk_rd, bk_last, bk_beats, bk_data};
            chk(g == e, e.rd ? "R4" : "R3", "bulk beat", 64'(g), 64'(e));
         end
         if (rcmd_valid && rcmd_ready) begin
            logic [HDR_W-1:0] e = rc_exp.size() > 0 ? rc_exp.pop_front() : '1;
            chk(rcmd_hdr == e, "R9", "return header", 64'(rcmd_hdr), 64'(e));
         end
         if (rdat_valid && rdat_ready) begin
            logic [DW-1:0] e = rd_exp.size() > 0 ? rd_exp.pop_front() : '1;
            chk(rdat_data == e, "R9", "return data", 64'(rdat_data), 64'(e));
         end
         if (!hold_out && hc_src.size() == 0 && hd_src.size() == 0 && ec_src.size() == 0
             && ed_src.size() == 0 && csr_exp.size() == 0 && bk_exp.size() == 0
             && rc_exp.size() == 0 && rd_exp.size() == 0 && q_empty == 4'hF) break;
      end
      @(negedge clk);
      {hcmd_valid, hdat_valid, ecmd_valid, edat_valid} = '0;
      {csr_ready, bk_ready, rcmd_ready, rdat_ready} = '0;
   endtask

   task automatic sweep();
      for (int k = 0; k < 2; k++) begin
         add_cmd(k[1:0], 32'h0000 + 32'(k) * 16'h1111);
         add_cmd(k[1:0], 32'hFFFF);
      end
      for (int l = 0; l <= 320; l += 32) add_cmd(2'b10, l);  // R3 legal, R5 illegal lengths
      add_cmd(2'b10, 100);                                   // R5 drops one beat
      add_cmd(2'b11, 64);                                    // R4
      add_cmd(2'b11, 4194304);                               // R4 upper bound
      add_cmd(2'b11, 4194304 + 64);                          // R5 above bound
      add_cmd(2'b11, 63);                                    // R5
      add_cmd(2'b11, 0);                                     // R5
      add_cmd(2'b00, 16'hBEEF);
      add_ret(12);
   endtask

   initial begin
      #400000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(q_empty == 4'hF && q_full == 4'h0, "R10", "queue flags after reset",
          {q_full, q_empty}, 8'h0F);
      chk(!csr_valid && !bk_valid && !rcmd_valid && !rdat_valid && !err_len, "R10",
          "outputs after reset", {csr_valid, bk_valid, rcmd_valid, rdat_valid, err_len}, 0);
      rst_n = 1;
      @(negedge clk);

      // R8: fill host-side queues with outputs stalled
      for (int i = 0; i < DP + 1; i++) add_cmd(2'b01, 32'(i));
      run(0, 1'b1, DP + 3);
      #1;
      chk(q_full[1:0] == 2'b11, "R8", "host queues full", q_full, 4'b0011);
      chk(!hcmd_ready && !hdat_ready, "R8", "ready low when full", {hcmd_ready, hdat_ready}, 0);
      chk(hc_src.size() == 1, "R8", "entries accepted", hc_src.size(), 1);
      chk(csr_valid, "R6", "header held while output stalled", csr_valid, 1);
      run(0, 1'b0, 2000);

      for (int p = 0; p < 3; p++) begin
         sweep();
         run(p * 40, 1'b0, 20000);
      end

      #1;
      chk(err_seen == err_exp, "R5", "error pulses", err_seen, err_exp);
      chk(q_empty == 4'hF, "R6", "all queues drained", q_empty, 4'hF);
      chk(csr_exp.size() + bk_exp.size() + rc_exp.size() + rd_exp.size() == 0, "R6",
          "undelivered beats", csr_exp.size() + bk_exp.size(), 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule